// File: doc/BRIEF.md
# HDB3 Line Encoder

This block turns a serial NRZ bit stream, one bit per clock at the 2.048 Mbit/s line rate, into high-density bipolar pseudo-ternary code on two rail outputs. One rail carries positive marks and the other negative marks. Ones become marks of alternating polarity. Every run of four zeros is replaced by a substitution pattern that contains a deliberate bipolar violation. This keeps enough transitions on the line for the far end to recover the clock. The rails are return-to-zero: each pulse is confined to the low half of the clock period.

A four-slot lookahead window holds the newest bits until it is known whether they belong to a zero run that needs substitution. Polarity is assigned only when a symbol leaves the window. As a result the rails lag the data input by a fixed four clocks. A second output returns the input data delayed by exactly one clock, for local use alongside the encoded line.

Top module: `hdb3_encoder`

## Requirements
- R1: While `rst` is high (synchronous, active high) and in the first cycle after it, both rails and `dq` are low. The encoder restarts with the last mark polarity taken as negative and the mark parity as even, so the first pulse after reset is positive.
- R2: Both rails are low whenever `clk` is high. A rail pulse appears only in the low half of a clock period.
- R3: `rail_pos` and `rail_neg` are never high at the same time.
- R4: `dq` equals `din` as sampled at the previous rising clock edge.
- R5: The symbol for the `din` bit sampled at rising edge k appears on the rails in the low half of the period after rising edge k+4. In the four periods after reset the rails stay low. A zero that is not part of a substitution produces no pulse.
- R6: Each input one that is not part of a substitution produces a mark of the polarity opposite to the previous mark. `rail_pos` high means a positive mark and `rail_neg` high means a negative mark.
- R7: When four consecutive zeros arrive and an odd number of marks has been sent since the last violation, they are sent as 0,0,0,V.
- R8: When four consecutive zeros arrive and an even number of marks (including none) has been sent since the last violation, they are sent as B,0,0,V. B is a normal alternating mark, and the mark count restarts at zero after each V.
- R9: A violation V has the same polarity as the mark before it. Successive violations alternate in polarity.
- R10: The rail stream decodes back to the input data. A pulse with the same polarity as the previous pulse is a violation, and that pulse and the position three bits before it decode as zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; rising edge samples `din`, low half carries rail pulses |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | NRZ data input |
| dq | output | 1 | `din` delayed by one clock |
| rail_pos | output | 1 | Positive-mark rail, return-to-zero |
| rail_neg | output | 1 | Negative-mark rail, return-to-zero |

## Verification
The hardest case to reach is the choice between the two substitution patterns. It depends on the parity of marks sent since the last violation, and in the B,0,0,V case it rewrites a symbol that entered three clocks earlier and is about to leave the window. The stimulus sets up each parity on purpose: zero runs directly after reset, runs of one, two and three ones ahead of four or more zeros, and long zero runs that chain substitutions back to back. A source biased towards zeros then mixes these cases, and a mid-stream reset repeats the start-up case. The bench rebuilds the data from the rails alone, so any misplaced B or V shows up as a decode error as well as a polarity error.

// File: rtl/hdb3_pkg.sv
package hdb3_pkg;

    // Symbol held in each lookahead slot, before polarity is assigned.
    typedef enum logic [1:0] {
        SYM_ZERO = 2'd0,   // no pulse
        SYM_MARK = 2'd1,   // ordinary alternating mark from an input one
        SYM_BSUB = 2'd2,   // alternating mark inserted by substitution
        SYM_VIOL = 2'd3    // violation, repeats the previous polarity
    } sym_e;

endpackage

// File: rtl/hdb3_window.sv
// Lookahead window: classifies incoming bits and rewrites zero runs.
module hdb3_window
    import hdb3_pkg::*;
#(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output sym_e oldest_o
);

    localparam int CNT_W = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
    localparam logic [CNT_W-1:0] ZMAX = CNT_W'(RUN_LEN - 1);

    typedef struct packed {
        sym_e [RUN_LEN-1:0] slot;   // slot[0] newest, slot[RUN_LEN-1] oldest
        logic [CNT_W-1:0]   zrun;   // zeros since last mark or substitution
        logic               odd;    // marks since last violation is odd
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        for (int i = RUN_LEN - 1; i > 0; i--) begin
            win_d.slot[i] = win_q.slot[i-1];
        end
        if (din) begin
            win_d.slot[0] = SYM_MARK;
            win_d.odd     = ~win_q.odd;
            win_d.zrun    = '0;
        end else if (win_q.zrun == ZMAX) begin
            // Fourth zero: close the run with a violation.
            win_d.slot[0] = SYM_VIOL;
            if (!win_q.odd) begin
                win_d.slot[RUN_LEN-1] = SYM_BSUB;
            end
            win_d.odd  = 1'b0;
            win_d.zrun = '0;
        end else begin
            win_d.slot[0] = SYM_ZERO;
            win_d.zrun    = win_q.zrun + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign oldest_o = win_q.slot[RUN_LEN-1];

endmodule

// File: rtl/hdb3_polarity.sv
// Assigns polarity to the symbol leaving the window and registers the rails.
module hdb3_polarity
    import hdb3_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  sym_e sym_i,
    output logic pos_o,
    output logic neg_o,
    output logic viol_o
);

    typedef struct packed {
        logic last_pos;   // polarity of the last mark, 1 = positive
        logic pos;
        logic neg;
        logic viol;
    } pol_t;

    pol_t pol_d, pol_q;

    always_comb begin
        pol_d      = pol_q;
        pol_d.pos  = 1'b0;
        pol_d.neg  = 1'b0;
        pol_d.viol = 1'b0;
        unique case (sym_i)
            SYM_MARK, SYM_BSUB: begin
                pol_d.last_pos = ~pol_q.last_pos;
                pol_d.pos      = ~pol_q.last_pos;
                pol_d.neg      =  pol_q.last_pos;
            end
            SYM_VIOL: begin
                pol_d.pos  =  pol_q.last_pos;
                pol_d.neg  = ~pol_q.last_pos;
                pol_d.viol = 1'b1;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q <= '0;
        end else begin
            pol_q <= pol_d;
        end
    end

    assign pos_o  = pol_q.pos;
    assign neg_o  = pol_q.neg;
    assign viol_o = pol_q.viol;

endmodule

// File: rtl/hdb3_rz_gate.sv
// Confines rail pulses to the low half of the clock (or passes them as NRZ).
module hdb3_rz_gate #(
    parameter bit RZ = 1'b1
) (
    input  logic clk,
    input  logic pos_i,
    input  logic neg_i,
    output logic pos_o,
    output logic neg_o
);

    generate
        if (RZ) begin : g_rz
            assign pos_o = pos_i & ~clk;
            assign neg_o = neg_i & ~clk;
        end else begin : g_nrz
            logic unused_clk;
            assign unused_clk = clk;
            assign pos_o = pos_i;
            assign neg_o = neg_i;
        end
    endgenerate

endmodule

// File: rtl/hdb3_encoder.sv
module hdb3_encoder
    import hdb3_pkg::*;
#(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dq,
    output logic rail_pos,
    output logic rail_neg
);

    sym_e oldest;
    logic pos_q;
    logic neg_q;
    logic viol_q;
    logic dq_d, dq_q;

    // One-clock copy of the input.
    always_comb begin
        dq_d = din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dq_q <= 1'b0;
        end else begin
            dq_q <= dq_d;
        end
    end

    assign dq = dq_q;

    hdb3_window #(.RUN_LEN(RUN_LEN)) i_window (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .oldest_o (oldest)
    );

    hdb3_polarity i_polarity (
        .clk    (clk),
        .rst    (rst),
        .sym_i  (oldest),
        .pos_o  (pos_q),
        .neg_o  (neg_q),
        .viol_o (viol_q)
    );

    hdb3_rz_gate #(.RZ(1'b1)) i_rz_gate (
        .clk   (clk),
        .pos_i (pos_q),
        .neg_i (neg_q),
        .pos_o (rail_pos),
        .neg_o (rail_neg)
    );

endmodule

// File: rtl/hdb3_encoder_chk.sv
module hdb3_encoder_chk (
    input logic clk,
    input logic rst,
    input logic din,
    input logic dq,
    input logic rail_pos,
    input logic rail_neg,
    input logic pos_q,
    input logic neg_q,
    input logic viol_q
);

    logic last_pos_c;   // polarity of the last non-violation pulse seen
    logic last_v_pos;   // polarity of the last violation seen
    logic seen_v;
    logic marks_odd;    // pulses since last violation is odd

    always_ff @(posedge clk) begin
        if (rst) begin
            last_pos_c <= 1'b0;
            last_v_pos <= 1'b0;
            seen_v     <= 1'b0;
            marks_odd  <= 1'b0;
        end else if (pos_q || neg_q) begin
            if (viol_q) begin
                last_v_pos <= pos_q;
                seen_v     <= 1'b1;
                marks_odd  <= 1'b0;
            end else begin
                last_pos_c <= pos_q;
                marks_odd  <= ~marks_odd;
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pos_q && !neg_q && !dq));                     // R1

    AST_RZ_HIGH_HALF: assert property (@(negedge clk) disable iff (rst)
        !(rail_pos || rail_neg));                                      // R2

    AST_ONE_RAIL: assert property (@(posedge clk) disable iff (rst)
        !(pos_q && neg_q));                                            // R3

    AST_DQ_DELAY: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (dq == $past(din)));                           // R4

    AST_MARK_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
        ((pos_q || neg_q) && !viol_q) |-> (pos_q == !last_pos_c));     // R6

    AST_ODD_BEFORE_V: assert property (@(posedge clk) disable iff (rst)
        viol_q |-> marks_odd);                                         // R7

    AST_V_REPEATS: assert property (@(posedge clk) disable iff (rst)
        viol_q |-> (pos_q == last_pos_c));                             // R9

    AST_V_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
        (viol_q && seen_v) |-> (pos_q != last_v_pos));                 // R9

endmodule

bind hdb3_encoder hdb3_encoder_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .din      (din),
    .dq       (dq),
    .rail_pos (rail_pos),
    .rail_neg (rail_neg),
    .pos_q    (pos_q),
    .neg_q    (neg_q),
    .viol_q   (viol_q)
);

// File: tb/test_hdb3_encoder.sv
module test_hdb3_encoder;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int RUN = 4;
    localparam int LAT = RUN;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic dq, rail_pos, rail_neg;

    hdb3_encoder #(.RUN_LEN(RUN)) i_hdb3_encoder (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .dq       (dq),
        .rail_pos (rail_pos),
        .rail_neg (rail_neg)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 0;

    bit    stim[$];
    int    sym_a[];    // 0 zero, 1 mark, 2 B, 3 V
    string tag_a[];
    int    dec_a[];
    int    m_zeros, m_odd, exp_last, dec_last, last_v;
    bit    seen_v, seen_pulse;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push_run(int ones, int zeros);
        for (int i = 0; i < ones; i++) stim.push_back(1'b1);
        for (int i = 0; i < zeros; i++) stim.push_back(1'b0);
    endtask

    task automatic push_rand(int n);
        for (int i = 0; i < n; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            stim.push_back(lfsr[0] & lfsr[5]);
        end
    endtask

    // Behavioural encoder: decides substitutions as bits arrive.
    task automatic model_push(int n);
        bit b;
        b = stim[n];
        sym_a[n] = b ? 1 : 0;
        tag_a[n] = b ? "R6" : "R5";
        if (b) begin
            m_odd   = m_odd ^ 1;
            m_zeros = 0;
        end else begin
            m_zeros++;
            if (m_zeros == RUN) begin
                sym_a[n] = 3;
                if (m_odd == 0) begin
                    sym_a[n-RUN+1] = 2;
                    for (int i = n - RUN + 1; i <= n; i++) tag_a[i] = "R8";
                end else begin
                    for (int i = n - RUN + 1; i <= n; i++) tag_a[i] = "R7";
                end
                m_odd   = 0;
                m_zeros = 0;
            end
        end
    endtask

    // Called in the low half after rising edge e.
    task automatic cycle_check(int e);
        int act;
        int j;
        int expv;
        chk("R4", "dq", dq, stim[e]);
        chk("R3", "both rails high", int'(rail_pos && rail_neg), 0);
        act = rail_pos ? 1 : (rail_neg ? -1 : 0);
        j = e - LAT;
        if (j < 0) begin
            chk("R5", "rails before first symbol", act, 0);
        end else begin
            case (sym_a[j])
                0:       expv = 0;
                1, 2:    begin exp_last = -exp_last; expv = exp_last; end
                default: expv = exp_last;
            endcase
            chk(tag_a[j], "rail symbol", act, expv);
            if (expv != 0 && !seen_pulse) begin
                chk("R1", "first pulse polarity", act, 1);
                seen_pulse = 1;
            end
            if (act == 0) begin
                dec_a[j] = 0;
            end else if (act == dec_last) begin
                if (seen_v) chk("R9", "violation alternation", int'(act != last_v), 1);
                seen_v = 1;
                last_v = act;
                dec_a[j] = 0;
                if (j >= RUN - 1) dec_a[j-RUN+1] = 0;
            end else begin
                dec_a[j] = 1;
                dec_last = act;
            end
            if (j >= RUN - 1) chk("R10", "decoded bit", dec_a[j-RUN+1], stim[j-RUN+1]);
        end
    endtask

    task automatic run_phase();
        push_run(0, RUN);   // flush so every real bit reaches the rails
        sym_a = new[stim.size()];
        tag_a = new[stim.size()];
        dec_a = new[stim.size()];
        rst = 1'b1;
        din = 1'b0;
        repeat (3) @(negedge clk);
        #2;
        chk("R1", "rail_pos in reset", rail_pos, 0);
        chk("R1", "rail_neg in reset", rail_neg, 0);
        chk("R1", "dq in reset", dq, 0);
        m_zeros = 0; m_odd = 0; exp_last = -1; dec_last = -1; last_v = 0;
        seen_v = 0; seen_pulse = 0;
        rst = 1'b0;
        for (int k = 0; k <= stim.size(); k++) begin
            if (k > 0) begin
                @(negedge clk);
                #2;
                cycle_check(k - 1);
            end
            if (k < stim.size()) begin
                din = stim[k];
                model_push(k);
                #5;
                chk("R2", "rail high in high half", int'(rail_pos || rail_neg), 0);
            end
        end
        stim.delete();
    endtask

    initial begin
        // Phase 1: chained substitutions from reset, then parity cases.
        push_run(0, 24);
        push_run(10, 0);
        push_run(1, 4);
        push_run(1, 5);
        push_run(2, 4);
        push_run(3, 4);
        push_run(1, 3);
        push_run(1, 7);
        push_run(1, 8);
        push_run(2, 11);
        push_run(3, 2);
        push_rand(600);
        run_phase();
        // Phase 2: reset mid-stream, substitution straight away.
        push_run(0, 4);
        push_run(1, 1);
        push_rand(400);
        push_run(0, 8);
        run_phase();
        $display("test done: total=%0d bad=%0d", total, bad);
        done = 1;
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule